// File: doc/BRIEF.md
# Cycle-Steal Bus Request Throttler

This block sequences bus access for one DMA channel that moves data by cycle stealing. A peripheral asks for service by holding an active-low request line. The block then raises a bus request to the system arbiter and waits for a grant. It owns the bus for exactly one transfer unit, which ends when the datapath pulses `unit_done_i`. It then hands the bus back. The datapath alone sets the unit size (byte, word, longword, 16-byte or 32-byte block), so the unit size does not affect this sequencer.

A 2-bit mode field chooses the spacing between units. In normal operation the next request can follow the release at once. In the two intermittent settings a gap counter holds off the next request for at least 16 or 64 bus clocks. This lowers the share of bus time taken by the channel. A count loaded at enable sets how many units move. After the last unit the block pulses `done_o` for one cycle and stays quiet until it is disabled and enabled again.

Top module: `cs_dma_throttle`

## Requirements
- R1: After reset, `bus_req_o`, `bus_own_o` and `done_o` are all low.
- R2: `dreq_ni` is sampled as an active-low level. While it is high and no unit is pending, `bus_req_o` stays low. Once it is sampled low, `bus_req_o` rises on the next cycle.
- R3: `bus_req_o` stays high until `bus_gnt_i` is sampled high. `bus_own_o` is then high from the next cycle until `unit_done_i` is sampled.
- R4: `bus_req_o` and `bus_own_o` are never high together. `bus_own_o` drops on the cycle after `unit_done_i` is sampled, so the bus is given back after every unit.
- R5: With mode 2'b00 or 2'b01 and `dreq_ni` low, `bus_req_o` rises on the first cycle after the last ownership cycle.
- R6: With mode 2'b10, `bus_req_o` rises 17 cycles after the last ownership cycle. This is a gap of 16 idle bus clocks.
- R7: With mode 2'b11, `bus_req_o` rises 65 cycles after the last ownership cycle. This is a gap of 64 idle bus clocks.
- R8: A request that is present during an intermittent gap is held. `bus_req_o` stays low until the gap has expired.
- R9: With a nonzero count N, exactly N units are moved. `done_o` is high for exactly one cycle, which is the cycle after the last unit's `unit_done_i`. No request follows until `en_i` goes low and then high again.
- R10: A count of zero at enable gives a one-cycle `done_o` and no bus request.
- R11: When `en_i` is sampled low, `bus_req_o` and `bus_own_o` are low on the next cycle and the gap counter is cleared. After re-enable, the first request is issued without any leftover gap.
- R12: The mode is captured when the grant is taken. A change to `mode_i` during a unit affects only the gap after the next unit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable; a rising edge loads the count |
| mode_i | input | 2 | Spacing mode: 10 = 16-clock gap, 11 = 64-clock gap, other = normal |
| count_i | input | CNT_W | Number of units to move, loaded at enable |
| dreq_ni | input | 1 | Peripheral transfer request, active-low level |
| bus_gnt_i | input | 1 | Grant from the bus arbiter |
| unit_done_i | input | 1 | Pulse marking the final cycle of a transfer unit |
| bus_req_o | output | 1 | Bus mastership request to the arbiter |
| bus_own_o | output | 1 | High while the channel owns the bus |
| done_o | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
Several properties are checked by assertions on every cycle:
- the request and ownership are mutually exclusive;
- the request is held until the grant arrives;
- ownership ends after the unit pulse;
- a disable clears the request and the gap counter;
- `done_o` lasts a single cycle;
- no request is raised while the gap counter runs;
- the unit count is never decremented past zero.

Only the bench scenarios can show the following:
- the exact gap lengths for each mode value;
- the number of units moved for each count;
- the capture of the mode at grant time;
- the behaviour for a zero count;
- the restart after a disable that happens in the middle of a gap.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_REQ, ST_XFER, ST_GAP, ST_HALT
  } cs_state_e;

  function automatic logic mode_spaced(input logic [1:0] m);
    return m[1];
  endfunction

  function automatic logic mode_long(input logic [1:0] m);
    return m == 2'b11;
  endfunction
endpackage

// File: rtl/cs_gap_timer.sv
module cs_gap_timer #(
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic long_i,
  output logic busy_o,
  output logic expire_o
);
  localparam int GW = $clog2(LONG_GAP + 1);
  localparam logic [GW-1:0] SHORT_V = GW'(SHORT_GAP);
  localparam logic [GW-1:0] LONG_V  = GW'(LONG_GAP);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (load_i)         cnt_q <= long_i ? LONG_V : SHORT_V;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o   = cnt_q != '0;
  assign expire_o = cnt_q == GW'(1);

  // R11
  gap_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
endmodule

// File: rtl/cs_unit_counter.sv
module cs_unit_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= value_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = cnt_q == CNT_W'(1);

  // R9
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> cnt_q != '0);
endmodule

// File: rtl/cs_dma_throttle.sv
module cs_dma_throttle
  import cs_dma_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SHORT_GAP = 16,
  parameter int LONG_GAP  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dreq_ni,
  input  logic             bus_gnt_i,
  input  logic             unit_done_i,
  output logic             bus_req_o,
  output logic             bus_own_o,
  output logic             done_o
);
  cs_state_e  st_q, st_d;
  logic [1:0] mode_q;
  logic       done_q;
  logic       cnt_load, cnt_dec, cnt_last;
  logic       gap_load, gap_busy, gap_expire;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    gap_load = 1'b0;
    if (!en_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_load = 1'b1;
          st_d     = (count_i == '0) ? ST_HALT : ST_ARM;
        end
        ST_ARM:  if (!dreq_ni) st_d = ST_REQ;
        ST_REQ:  if (bus_gnt_i) st_d = ST_XFER;
        ST_XFER: if (unit_done_i) begin
          cnt_dec = 1'b1;
          if (cnt_last)                  st_d = ST_HALT;
          else if (mode_spaced(mode_q)) begin
            gap_load = 1'b1;
            st_d     = ST_GAP;
          end
          else                           st_d = dreq_ni ? ST_ARM : ST_REQ;
        end
        ST_GAP:  if (gap_expire) st_d = dreq_ni ? ST_ARM : ST_REQ;
        ST_HALT: st_d = ST_HALT;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= 2'b00;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= en_i && (st_d == ST_HALT) && (st_q != ST_HALT);
      // mode is frozen per unit at grant
      if (st_q == ST_REQ && bus_gnt_i) mode_q <= mode_i;
    end
  end

  cs_unit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cnt_load),
    .value_i (count_i),
    .dec_i   (cnt_dec),
    .last_o  (cnt_last)
  );

  cs_gap_timer #(.SHORT_GAP(SHORT_GAP), .LONG_GAP(LONG_GAP)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!en_i),
    .load_i   (gap_load),
    .long_i   (mode_long(mode_q)),
    .busy_o   (gap_busy),
    .expire_o (gap_expire)
  );

  assign bus_req_o = st_q == ST_REQ;
  assign bus_own_o = st_q == ST_XFER;
  assign done_o    = done_q;

  // R4
  req_own_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_req_o && bus_own_o));
  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_gnt_i && en_i |=> bus_req_o);
  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_own_o && unit_done_i |=> !bus_own_o);
  // R8
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_busy |-> !bus_req_o);
  // R11
  disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bus_req_o && !bus_own_o && !done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: tb/sim_cs_dma_throttle.sv
module sim_cs_dma_throttle;
  localparam int CNT_W = 16;

  logic clk = 0, rst_n = 0;
  logic en = 0, dreq_n = 1, gnt = 0, udone = 0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] count = '0;
  logic req, own, done;

  always #5 clk = ~clk;

  cs_dma_throttle #(.CNT_W(CNT_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .mode_i(mode), .count_i(count),
    .dreq_ni(dreq_n), .bus_gnt_i(gnt), .unit_done_i(udone),
    .bus_req_o(req), .bus_own_o(own), .done_o(done)
  );

  int errors = 0, checks = 0;
  int cyc = 0;
  int exp_gap[$];
  string exp_tag[$];
  int units = 0, dones = 0, done_run = 0;
  logic gnt_en = 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // arbiter and datapath model: grant one cycle after request, unit of 3 cycles
  int own_n = 0;
  always @(negedge clk) begin
    gnt <= req && gnt_en;
    if (own) begin
      own_n = own_n + 1;
      udone <= (own_n == 3);
    end else begin
      own_n = 0;
      udone <= 1'b0;
    end
  end

  // monitor / scoreboard
  logic req_p = 0, own_p = 0, own_seen = 0;
  int own_last = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (own && !own_p) units++;
      if (own) begin own_last = cyc; own_seen = 1; end
      if (!en) own_seen = 0;
      if (done) begin dones++; done_run++; end else done_run = 0;
      if (done_run > 1) chk(0, "R9 done width", done_run, 1);
      if (req && !req_p && own_seen) begin
        if (exp_gap.size() == 0) chk(0, "unexpected request", cyc - own_last, -1);
        else begin
          string t;
          int g;
          g = exp_gap.pop_front();
          t = exp_tag.pop_front();
          chk(cyc - own_last == g, t, cyc - own_last, g);
        end
      end
    end
    req_p = req;
    own_p = own;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start(input logic [1:0] m, input int n);
    en = 0; cycles(2);
    units = 0; dones = 0;
    mode = m; count = CNT_W'(n);
    en = 1;
  endtask

  task automatic push(input int g, input string t, input int k);
    for (int i = 0; i < k; i++) begin exp_gap.push_back(g); exp_tag.push_back(t); end
  endtask

  task automatic finish_run(input int n, input string tag);
    int lim = 0;
    while (dones == 0 && lim < 3000) begin cycles(1); lim++; end
    cycles(5);
    chk(units == n, {tag, " R9 units"}, units, n);
    chk(dones == 1, {tag, " R9 done count"}, dones, 1);
    chk(exp_gap.size() == 0, {tag, " gaps left"}, exp_gap.size(), 0);
    chk(req == 0, "R9 no request after done", req, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1;
    cycles(1);
    chk(req == 0 && own == 0 && done == 0, "R1 reset", {req, own, done}, 0);

    dreq_n = 0;
    push(1, "R5 mode00 gap", 2);
    start(2'b00, 3); finish_run(3, "R5");

    push(1, "R5 mode01 gap", 1);
    start(2'b01, 2); finish_run(2, "R5");

    push(17, "R6 R8 mode10 gap", 2);
    start(2'b10, 3); finish_run(3, "R6");

    push(65, "R7 R8 mode11 gap", 1);
    start(2'b11, 2); finish_run(2, "R7");

    // R12: mode captured at grant
    push(17, "R12 old mode kept", 1);
    push(1, "R12 new mode next unit", 1);
    start(2'b10, 3);
    while (!own) cycles(1);
    mode = 2'b00;
    finish_run(3, "R12");

    // R2: request line high blocks, low starts
    dreq_n = 1;
    start(2'b00, 1);
    cycles(10);
    chk(req == 0, "R2 no request while dreq high", req, 0);
    dreq_n = 0;
    cycles(1);
    chk(req == 1, "R2 request after dreq low", req, 1);
    finish_run(1, "R2");

    // R3: request held until grant
    gnt_en = 0;
    start(2'b00, 1);
    while (!req) cycles(1);
    cycles(8);
    chk(req == 1 && own == 0, "R3 request held", {req, own}, 2);
    gnt_en = 1;
    cycles(2);
    chk(own == 1, "R3 ownership after grant", own, 1);
    finish_run(1, "R3");

    // R10: zero count
    start(2'b00, 0);
    cycles(6);
    chk(dones == 1, "R10 done on zero count", dones, 1);
    chk(units == 0, "R10 no unit moved", units, 0);

    // R11: disable during gap, then restart without leftover gap
    start(2'b11, 5);
    while (!own) cycles(1);
    while (own) cycles(1);
    cycles(5);
    en = 0;
    cycles(1);
    chk(req == 0 && own == 0, "R11 outputs low after disable", {req, own}, 0);
    cycles(2);
    mode = 2'b00; count = CNT_W'(1); units = 0; dones = 0;
    en = 1;
    cycles(2);
    chk(req == 1, "R11 immediate request after re-enable", req, 1);
    finish_run(1, "R11");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule